// File: doc/BRIEF.md
# Capacitor Role Shuffling Controller

This block drives the bottom-plate switches for one side of a pipelined converter stage built from four equal capacitors. On each conversion cycle it takes the three 2-bit DAC connection codes from the stage's sub-converter and one fixed code that means "connect to the amplifier output". It scatters these four codes across the four capacitors through a two-level butterfly of swap cells. So one capacitor, picked at random, becomes the feedback element. The other three take the DAC codes in a random order. Over time, every capacitor passes through every role, and both the reference error and the gain error caused by capacitor mismatch average out.

The swap cells are steered by a 16-bit linear feedback shift register on chip. The selection logic is a shallow mux tree. It can therefore settle inside the short non-overlap window ahead of the decision latches. An enable input turns shuffling off for later, less critical stages. When it is off, the codes pass straight through, and the last capacitor is the feedback element.

Top module: `capshuf_top`

## Requirements
- R1: While the synchronous reset `rst` is sampled high, the next edge loads `capSel` with the identity mapping of the present inputs: capacitor j (j = 0..2) gets `dacCodes[2j+1:2j]`, and capacitor 3 gets the amplifier-output code 2'b11. The same edge reloads the shift register with seed 16'hACE1.
- R2: `capSel` is registered. The result for the inputs present before a rising edge appears right after that edge and holds until the next edge.
- R3: When every DAC code is 2'b00 (positive reference), 2'b01 (common mode) or 2'b10 (negative reference), exactly one capacitor carries 2'b11 each cycle, and `fbOneHot` marks that capacitor.
- R4: The codes in `capSel` are a rearrangement of the four input codes. Each code value occurs in the output as often as it occurred in the registered inputs.
- R5: With swap bits s[3:0] equal to the low four bits of the shift register, the input slots are v0..v2 = DAC codes and v3 = 2'b11. The first level forms m from v: s0 swaps slots 0 and 2, and s1 swaps slots 1 and 3. The second level forms the output from m: s2 swaps slots 0 and 1, and s3 swaps slots 2 and 3. The output slot k drives capacitor k.
- R6: The shift register advances once per enabled cycle. It shifts left, and its new bit 0 is bit15 ^ bit13 ^ bit12 ^ bit10. It is never all zeros.
- R7: With `en` low, the mapping is the identity of R1 and the shift register holds its value. When `en` returns high, shuffling resumes from the held state.
- R8: Over 4096 enabled cycles after reset, each capacitor is the feedback element between 20% and 30% of the time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Shuffling enable; low gives the identity mapping |
| dacCodes | input | 6 | Three 2-bit DAC connection codes, code j at bits [2j+1:2j] |
| capSel | output | 8 | Registered bottom-plate select code, capacitor k at bits [2k+1:2k] |
| fbOneHot | output | 4 | One bit per capacitor, set where the amplifier-output code sits |

## Verification
Every result of this block is due one rising edge after its stimulus. This applies to the permuted select codes, the feedback marker, the reset identity and the held mapping when disabled. The shift register also moves on that edge, so the swap bits used for cycle n come from the state after n-1 enabled edges. The bench drives on the falling edge and samples `capSel` and `fbOneHot` on the next falling edge. It then advances its own model of the shift register only for cycles where `en` was high.

// File: rtl/capshuf_pkg.sv
package capshuf_pkg;
  localparam int CODE_W    = 2;
  localparam int CAP_COUNT = 4;
  localparam int CAP_LOG   = $clog2(CAP_COUNT);
  localparam int SWAP_W    = CAP_LOG * (CAP_COUNT / 2);
  localparam int HIST_W    = $clog2(CAP_COUNT + 1);

  localparam logic [CODE_W-1:0] CODE_VREFP = 2'b00;
  localparam logic [CODE_W-1:0] CODE_VCM   = 2'b01;
  localparam logic [CODE_W-1:0] CODE_VREFN = 2'b10;
  localparam logic [CODE_W-1:0] CODE_OPOUT = 2'b11;

  typedef struct packed {
    logic              shuffle;
    logic [SWAP_W-1:0] swap;
  } shufStrobe_t;
endpackage

// File: rtl/capshuf_ctrl.sv
module capshuf_ctrl
  import capshuf_pkg::*;
#(
  parameter int          LFSR_W    = 16,
  parameter logic [15:0] LFSR_TAPS = 16'hB400,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        en,
  output shufStrobe_t strobe
);
  logic [LFSR_W-1:0] lfsrQ;
  logic              feedBit;

  assign feedBit = ^(lfsrQ & LFSR_TAPS[LFSR_W-1:0]);

  always_ff @(posedge clk) begin
    if (rst)     lfsrQ <= LFSR_SEED[LFSR_W-1:0];
    else if (en) lfsrQ <= {lfsrQ[LFSR_W-2:0], feedBit};
  end

  always_comb begin
    strobe.shuffle = en;
    strobe.swap    = en ? lfsrQ[SWAP_W-1:0] : '0;
  end

  AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (rst)
    lfsrQ != '0);  // R6
  AST_LFSR_STEP: assert property (@(posedge clk) disable iff (rst)
    en |=> lfsrQ[LFSR_W-1:1] == $past(lfsrQ[LFSR_W-2:0]));  // R6
  AST_LFSR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(lfsrQ));  // R7
endmodule

// File: rtl/capshuf_net.sv
module capshuf_net
  import capshuf_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst,
  input  shufStrobe_t                   strobe,
  input  logic [(CAP_COUNT-1)*CODE_W-1:0] dacCodes,
  output logic [CAP_COUNT*CODE_W-1:0]   capSel
);
  localparam int HALF = CAP_COUNT / 2;

  logic [CODE_W-1:0]           stageVal [CAP_LOG+1][CAP_COUNT];
  logic [CAP_COUNT*CODE_W-1:0] inPacked;
  logic [CAP_COUNT*CODE_W-1:0] netPacked;
  logic [SWAP_W-1:0]           swapUse;

  assign swapUse = rst ? '0 : strobe.swap;

  for (genvar j = 0; j < CAP_COUNT; j++) begin : g_in
    if (j < CAP_COUNT - 1) begin : g_dac
      assign stageVal[0][j] = dacCodes[j*CODE_W +: CODE_W];
    end else begin : g_fb
      assign stageVal[0][j] = CODE_OPOUT;
    end
    assign inPacked[j*CODE_W +: CODE_W]  = stageVal[0][j];
    assign netPacked[j*CODE_W +: CODE_W] = stageVal[CAP_LOG][j];
  end

  for (genvar k = 0; k < CAP_LOG; k++) begin : g_stage
    localparam int DIST = HALF >> k;
    for (genvar i = 0; i < HALF; i++) begin : g_cell
      localparam int LO = (i / DIST) * 2 * DIST + (i % DIST);
      localparam int HI = LO + DIST;
      logic swapBit;
      assign swapBit = swapUse[k*HALF + i];
      assign stageVal[k+1][LO] = swapBit ? stageVal[k][HI] : stageVal[k][LO];
      assign stageVal[k+1][HI] = swapBit ? stageVal[k][LO] : stageVal[k][HI];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !strobe.shuffle) capSel <= inPacked;
    else                        capSel <= netPacked;
  end

  // assertion support: code histograms and feedback mask
  logic [HIST_W-1:0]    inHist  [4];
  logic [HIST_W-1:0]    outHist [4];
  logic [CAP_COUNT-1:0] fbMask;
  logic                 dacValid;

  always_comb begin
    dacValid = 1'b1;
    for (int h = 0; h < 4; h++) begin
      inHist[h]  = '0;
      outHist[h] = '0;
    end
    for (int c = 0; c < CAP_COUNT; c++) begin
      inHist[inPacked[c*CODE_W +: CODE_W]]  = inHist[inPacked[c*CODE_W +: CODE_W]] + 1'b1;
      outHist[capSel[c*CODE_W +: CODE_W]]   = outHist[capSel[c*CODE_W +: CODE_W]] + 1'b1;
      fbMask[c] = (capSel[c*CODE_W +: CODE_W] == CODE_OPOUT);
      if (c < CAP_COUNT - 1 && inPacked[c*CODE_W +: CODE_W] == CODE_OPOUT) dacValid = 1'b0;
    end
  end

  AST_RESET_IDENT: assert property (@(posedge clk)
    rst |=> capSel == $past(inPacked));  // R1
  AST_IDLE_IDENT: assert property (@(posedge clk) disable iff (rst)
    !strobe.shuffle |=> capSel == $past(inPacked));  // R7
  AST_ONE_FB: assert property (@(posedge clk) disable iff (rst)
    $past(dacValid) |-> $countones(fbMask) == 1);  // R3
  AST_HIST_VREFP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> outHist[0] == $past(inHist[0]));  // R4
  AST_HIST_VCM: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> outHist[1] == $past(inHist[1]));  // R4
  AST_HIST_VREFN: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> outHist[2] == $past(inHist[2]));  // R4
endmodule

// File: rtl/capshuf_top.sv
module capshuf_top
  import capshuf_pkg::*;
#(
  parameter int          LFSR_W    = 16,
  parameter logic [15:0] LFSR_TAPS = 16'hB400,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            en,
  input  logic [(CAP_COUNT-1)*CODE_W-1:0] dacCodes,
  output logic [CAP_COUNT*CODE_W-1:0]     capSel,
  output logic [CAP_COUNT-1:0]            fbOneHot
);
  shufStrobe_t strobe;

  capshuf_ctrl #(
    .LFSR_W   (LFSR_W),
    .LFSR_TAPS(LFSR_TAPS),
    .LFSR_SEED(LFSR_SEED)
  ) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .strobe(strobe)
  );

  capshuf_net u_net (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .dacCodes(dacCodes),
    .capSel  (capSel)
  );

  for (genvar c = 0; c < CAP_COUNT; c++) begin : g_fbmark
    assign fbOneHot[c] = (capSel[c*CODE_W +: CODE_W] == CODE_OPOUT);
  end

  AST_FB_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(fbOneHot));  // R3
endmodule

// File: tb/capshuf_top_bench.sv
module capshuf_top_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic [5:0] dacCodes = 6'b10_01_00;
  logic [7:0] capSel;
  logic [3:0] fbOneHot;

  int testsRun = 0;
  int testsFailed = 0;
  logic [15:0] modelLfsr;
  int fbCount [4];

  always #4 clk = ~clk;

  capshuf_top u_capshuf_top (
    .clk(clk), .rst(rst), .en(en),
    .dacCodes(dacCodes), .capSel(capSel), .fbOneHot(fbOneHot)
  );

  // stimulus table: {en, dac2, dac1, dac0}
  localparam logic [6:0] VECS [10] = '{
    7'b1_10_01_00, 7'b1_00_00_00, 7'b1_01_01_01, 7'b1_10_10_10,
    7'b1_00_10_01, 7'b0_01_10_00, 7'b1_10_00_01, 7'b0_00_01_10,
    7'b1_01_00_10, 7'b1_00_01_10
  };

  function automatic logic [15:0] lfsrNext(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic logic [7:0] permute(input logic [5:0] d, input logic [3:0] s);
    logic [1:0] v [4];
    logic [1:0] m [4];
    logic [1:0] o [4];
    v[0] = d[1:0]; v[1] = d[3:2]; v[2] = d[5:4]; v[3] = 2'b11;
    m[0] = s[0] ? v[2] : v[0];  m[2] = s[0] ? v[0] : v[2];
    m[1] = s[1] ? v[3] : v[1];  m[3] = s[1] ? v[1] : v[3];
    o[0] = s[2] ? m[1] : m[0];  o[1] = s[2] ? m[0] : m[1];
    o[2] = s[3] ? m[3] : m[2];  o[3] = s[3] ? m[2] : m[3];
    return {o[3], o[2], o[1], o[0]};
  endfunction

  function automatic logic [3:0] fbMarks(input logic [7:0] sel);
    logic [3:0] r;
    for (int c = 0; c < 4; c++) r[c] = (sel[2*c +: 2] == 2'b11);
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // called at a falling edge: drive, wait one rising edge, sample at next falling edge
  task automatic stepCheck(input logic enV, input logic [5:0] d, input string req);
    logic [7:0] exp;
    en = enV; dacCodes = d;
    exp = enV ? permute(d, modelLfsr[3:0]) : {2'b11, d};
    @(posedge clk); @(negedge clk);
    check(capSel == exp, req, {8'h0, capSel}, {8'h0, exp});                 // R2 R5
    check(fbOneHot == fbMarks(exp), "R3", {12'h0, fbOneHot}, {12'h0, fbMarks(exp)});
    if (enV) modelLfsr = lfsrNext(modelLfsr);                                // R6
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    // R1: reset gives identity, capacitor 3 feedback
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(capSel == 8'b11_10_01_00, "R1", {8'h0, capSel}, 16'h00E4);
    check(fbOneHot == 4'b1000, "R1", {12'h0, fbOneHot}, 16'h8);
    rst = 1'b0;
    modelLfsr = 16'hACE1;

    // table walk: R5 exact butterfly routing, R7 identity when disabled
    foreach (VECS[i]) stepCheck(VECS[i][6], VECS[i][5:0], VECS[i][6] ? "R5" : "R7");

    // R7: long disabled stretch holds the register; resumes on same sequence
    for (int i = 0; i < 5; i++) stepCheck(1'b0, 6'b00_10_01, "R7");
    for (int i = 0; i < 4; i++) stepCheck(1'b1, 6'b01_00_10, "R7");

    // R1: mid-run reset reloads seed
    en = 1'b1; rst = 1'b1; dacCodes = 6'b00_01_10;
    @(posedge clk); @(negedge clk);
    check(capSel == 8'b11_00_01_10, "R1", {8'h0, capSel}, 16'h00C6);
    rst = 1'b0;
    modelLfsr = 16'hACE1;
    stepCheck(1'b1, 6'b10_01_00, "R1");

    // R8 / R4 / R6: long enabled run with random valid codes
    rst = 1'b1; @(posedge clk); @(negedge clk); rst = 1'b0;
    modelLfsr = 16'hACE1;
    for (int c = 0; c < 4; c++) fbCount[c] = 0;
    for (int n = 0; n < 4096; n++) begin
      logic [5:0] d;
      d = {2'($urandom_range(0, 2)), 2'($urandom_range(0, 2)), 2'($urandom_range(0, 2))};
      stepCheck(1'b1, d, "R6");
      for (int c = 0; c < 4; c++) if (fbOneHot[c]) fbCount[c]++;
    end
    for (int c = 0; c < 4; c++)
      check(fbCount[c] >= 819 && fbCount[c] <= 1229, "R8", 16'(fbCount[c]), 16'd1024);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule